// File: doc/BRIEF.md
# Parallel Display Write Capture

This block receives the writes that an old host sends over an 8-bit parallel display bus. It converts each write into a single byte for logic that runs on a fast system clock. The bus lines are eight data bits, a register-select bit, an active-low chip select and an active-low write strobe. These lines are asynchronous to the system clock. Every line passes through a synchronizer. The block then samples the whole bus on every clock and keeps the previous sample. When the strobe reads high for the first time after a low interval, the byte and the register-select bit are taken from the previous sample, in which the strobe was still low. This means no settling delay inside the strobe pulse has to be known.

A captured byte stays in a holding register and is offered downstream with a valid flag. The consumer takes it by pulsing ready. From the end of the strobe until that acknowledgement, a busy line is driven back to the host so that it waits before sending the next character. The clock period must be well below the roughly 100 ns in which data is valid, so that at least two samples fall inside each low pulse of the strobe. If a write still completes while a byte is pending, that write is dropped and a sticky overrun flag records it.

Top module: `pbus_write_capture`

## Requirements
- R1: While reset is high and on the first clock after it, cap_valid_o, host_busy_o and overrun_o are 0. Reset is synchronous and active-high, and the synchronized strobe history idles high.
- R2: If bus_wr_n_i rises while bus_cs_n_i was low during the write, cap_valid_o and host_busy_o go to 1 on the third rising clock edge after the strobe input changes. They are still 0 after the second edge. cap_data_o and cap_rs_o then hold the data and register-select values that were present while the strobe was low.
- R3: The captured values come from the last sample in which the strobe was low. If the data and register-select inputs change in the same cycle as the strobe rises, the old values are captured.
- R4: A strobe pulse during which chip select is high (1) is ignored: cap_valid_o stays 0 and the held byte does not change.
- R5: While cap_valid_o is 1 and cap_ready_i is 0, cap_valid_o stays 1 and cap_data_o and cap_rs_o stay stable.
- R6: If cap_ready_i is 1 on a rising edge while cap_valid_o is 1, cap_valid_o and host_busy_o are 0 after that edge.
- R7: host_busy_o equals cap_valid_o on every cycle outside reset. Busy is raised when the strobe ends and lowered by the acknowledgement.
- R8: A write that completes while a capture is pending is dropped, even if ready is given in the same cycle. The held data is not changed, and overrun_o goes to 1 on the same edge on which a valid would have risen.
- R9: overrun_o stays 1 until reset. A ready pulse and later writes do not clear it.
- R10: Each low pulse of the strobe yields exactly one capture, whatever its length. Nothing is captured while the strobe is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data_i | input | 8 | Asynchronous bus data lines |
| bus_rs_i | input | 1 | Asynchronous register-select line |
| bus_cs_n_i | input | 1 | Asynchronous chip select, active low |
| bus_wr_n_i | input | 1 | Asynchronous write strobe, active low |
| cap_valid_o | output | 1 | A captured byte is pending |
| cap_data_o | output | 8 | Captured data byte |
| cap_rs_o | output | 1 | Captured register-select bit |
| cap_ready_i | input | 1 | Consumer acknowledgement pulse |
| host_busy_o | output | 1 | Busy line back to the host |
| overrun_o | output | 1 | Sticky flag: a write was dropped |

## Verification
A capture is due on the third rising edge after the strobe input rises: two synchronizer edges, then the edge that registers the capture. For every write, the bench checks at the falling edge after the second rising edge that valid is still low, and at the falling edge after the third that it is high with the expected byte. An acknowledgement clears valid and busy on the first edge. The bench holds ready for one cycle and checks at the falling edge that follows. Inputs change only on falling edges and outputs are read only there, so each expected value belongs to one counted edge.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic             rs;
    logic             cs_n;
    logic             wr_n;
  } bus_sample_t;

  // Idle bus: strobe and select deasserted.
  function automatic bus_sample_t idle_sample();
    bus_sample_t s;
    s.data = '0;
    s.rs   = 1'b0;
    s.cs_n = 1'b1;
    s.wr_n = 1'b1;
    return s;
  endfunction

  // End of a write: strobe low in the older sample, high in the newer one.
  function automatic logic strobe_ended(bus_sample_t older, bus_sample_t newer);
    return (!older.wr_n) && newer.wr_n;
  endfunction

  // A write counts when the sample holding the data also had select low.
  function automatic logic selected(bus_sample_t s);
    return !s.cs_n;
  endfunction
endpackage

// File: rtl/pbw_sync.sv
module pbw_sync
  import pbw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  bus_sample_t raw_i,
  output bus_sample_t sync_o
);
  localparam int LAST = STAGES - 1;

  bus_sample_t chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= idle_sample();
          else     chain[g] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= idle_sample();
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[LAST];
endmodule

// File: rtl/pbw_edge.sv
module pbw_edge
  import pbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  bus_sample_t cur_i,
  output bus_sample_t prev_o,
  output logic        wr_done_o,
  output logic        wr_accept_o,
  output logic        wr_ignored_o
);
  bus_sample_t prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= idle_sample();
    else     prev_q <= cur_i;
  end

  assign prev_o       = prev_q;
  assign wr_done_o    = strobe_ended(prev_q, cur_i);
  assign wr_accept_o  = wr_done_o && selected(prev_q);
  assign wr_ignored_o = wr_done_o && !selected(prev_q);

  // R10: one strobe end cannot be reported on two consecutive cycles
  a_r10_single_event: assert property (@(posedge clk) disable iff (rst)
    wr_done_o |=> !wr_done_o);
endmodule

// File: rtl/pbw_hold.sv
module pbw_hold
  import pbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic             rs_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [BUS_W-1:0] data_o,
  output logic             rs_o,
  output logic             busy_o,
  output logic             overrun_o
);
  logic             valid_q, busy_q, ovr_q, rs_q;
  logic [BUS_W-1:0] data_q;
  logic             take, drop, release_v, release_b;

  assign take      = accept_i && !valid_q;
  assign drop      = accept_i && valid_q;
  assign release_v = ready_i && valid_q;
  assign release_b = ready_i && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      rs_q    <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
      rs_q    <= rs_i;
    end else if (release_v) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            busy_q <= 1'b0;
    else if (take)      busy_q <= 1'b1;
    else if (release_b) busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       ovr_q <= 1'b0;
    else if (drop) ovr_q <= 1'b1;
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign rs_o      = rs_q;
  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;

  a_r5_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q) && $stable(rs_q)));
  a_r6_ready_clears: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ready_i && !accept_i) |=> (!valid_q && !busy_q));
  a_r7_busy_matches: assert property (@(posedge clk) disable iff (rst)
    busy_q == valid_q);
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (valid_q && accept_i) |=> (ovr_q && $stable(data_q)));
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/pbus_write_capture.sv
module pbus_write_capture
  import pbw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_data_i,
  input  logic             bus_rs_i,
  input  logic             bus_cs_n_i,
  input  logic             bus_wr_n_i,
  output logic             cap_valid_o,
  output logic [BUS_W-1:0] cap_data_o,
  output logic             cap_rs_o,
  input  logic             cap_ready_i,
  output logic             host_busy_o,
  output logic             overrun_o
);
  bus_sample_t raw, cur, prev;
  logic        wr_done, wr_accept, wr_ignored;

  assign raw.data = bus_data_i;
  assign raw.rs   = bus_rs_i;
  assign raw.cs_n = bus_cs_n_i;
  assign raw.wr_n = bus_wr_n_i;

  pbw_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .raw_i(raw), .sync_o(cur)
  );

  pbw_edge i_edge (
    .clk(clk), .rst(rst), .cur_i(cur), .prev_o(prev),
    .wr_done_o(wr_done), .wr_accept_o(wr_accept), .wr_ignored_o(wr_ignored)
  );

  pbw_hold i_hold (
    .clk(clk), .rst(rst), .accept_i(wr_accept),
    .data_i(prev.data), .rs_i(prev.rs), .ready_i(cap_ready_i),
    .valid_o(cap_valid_o), .data_o(cap_data_o), .rs_o(cap_rs_o),
    .busy_o(host_busy_o), .overrun_o(overrun_o)
  );

  // R4: an unselected strobe never raises valid from idle
  a_r4_unselected_ignored: assert property (@(posedge clk) disable iff (rst)
    (!cap_valid_o && wr_ignored) |=> !cap_valid_o);
  // R2: a selected strobe end raises valid and busy on the next edge
  a_r2_capture_next: assert property (@(posedge clk) disable iff (rst)
    (!cap_valid_o && wr_accept) |=> (cap_valid_o && host_busy_o));
  // R1: after reset the outputs are idle
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!cap_valid_o && !host_busy_o && !overrun_o));
endmodule

// File: tb/test_pbus_write_capture.sv
module test_pbus_write_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] d = 8'h00;
  logic       rs = 1'b0, cs_n = 1'b1, wr_n = 1'b1, ready = 1'b0;
  logic       valid, busy, ovr, crs;
  logic [7:0] cdata;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  pbus_write_capture i_pbus_write_capture (
    .clk(clk), .rst(rst), .bus_data_i(d), .bus_rs_i(rs), .bus_cs_n_i(cs_n),
    .bus_wr_n_i(wr_n), .cap_valid_o(valid), .cap_data_o(cdata), .cap_rs_o(crs),
    .cap_ready_i(ready), .host_busy_o(busy), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Strobe low for low_n cycles; returns at the negedge where the strobe rose.
  task automatic bus_write(input logic [7:0] dv, input logic rv, input logic csv,
                           input int low_n, input bit swap_at_end);
    @(negedge clk);
    d = dv; rs = rv; cs_n = csv; wr_n = 1'b0;
    repeat (low_n) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    if (swap_at_end) begin d = ~dv; rs = ~rv; end
  endtask

  task automatic ack();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    chk(!valid, "R6 valid cleared", valid, 0);
    chk(!busy, "R6 busy cleared", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 during and after reset
    repeat (2) @(negedge clk);
    chk(!valid && !busy && !ovr, "R1 in reset", {valid, busy, ovr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!valid && !busy && !ovr, "R1 after reset", {valid, busy, ovr}, 0);

    // R2 R7: sweep every byte value with alternating select bit
    for (int v = 0; v < 256; v++) begin
      bus_write(v[7:0], v[0] ^ v[3], 1'b0, 2 + (v % 4), 0);
      repeat (2) @(negedge clk);
      chk(!valid, "R2 not early", valid, 0);
      @(negedge clk);
      chk(valid && busy, "R2 R7 valid and busy", {valid, busy}, 3);
      chk(cdata == v[7:0] && crs == (v[0] ^ v[3]), "R2 data",
          {crs, cdata}, {v[0] ^ v[3], v[7:0]});
      ack();
    end

    // R3: data changes together with strobe rise, old value captured
    for (int v = 0; v < 16; v++) begin
      bus_write(8'h5A + v[7:0], v[0], 1'b0, 3, 1);
      repeat (3) @(negedge clk);
      chk(valid && cdata == 8'h5A + v[7:0] && crs == v[0], "R3 prior sample",
          {crs, cdata}, {v[0], 8'h5A + v[7:0]});
      ack();
    end

    // R4: chip select high, nothing captured
    bus_write(8'hC3, 1'b1, 1'b1, 4, 0);
    repeat (6) begin
      @(negedge clk);
      chk(!valid && !busy, "R4 ignored", {valid, busy}, 0);
    end
    bus_write(8'h11, 1'b0, 1'b0, 3, 0);
    repeat (3) @(negedge clk);
    chk(cdata == 8'h11, "R4 next write unaffected", cdata, 8'h11);

    // R5: held without ready
    repeat (10) begin
      @(negedge clk);
      chk(valid && cdata == 8'h11 && crs == 1'b0, "R5 stable", {valid, cdata}, {1'b1, 8'h11});
    end

    // R8: write while pending dropped, overrun set
    chk(!ovr, "R8 no overrun yet", ovr, 0);
    bus_write(8'hEE, 1'b1, 1'b0, 3, 0);
    repeat (2) @(negedge clk);
    chk(!ovr, "R8 overrun not early", ovr, 0);
    @(negedge clk);
    chk(ovr, "R8 overrun set", ovr, 1);
    chk(cdata == 8'h11 && crs == 1'b0, "R8 data kept", cdata, 8'h11);

    // R9: sticky across ack and new writes
    ack();
    chk(ovr, "R9 sticky after ready", ovr, 1);
    bus_write(8'h22, 1'b1, 1'b0, 2, 0);
    repeat (3) @(negedge clk);
    chk(valid && cdata == 8'h22, "R9 normal capture", cdata, 8'h22);
    chk(ovr, "R9 still set", ovr, 1);
    ack();

    // R8: write completing in the same cycle as ready is still dropped
    bus_write(8'h33, 1'b0, 1'b0, 2, 0);
    repeat (3) @(negedge clk);
    bus_write(8'h44, 1'b0, 1'b0, 2, 0);
    @(negedge clk); @(negedge clk);
    ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    chk(!valid, "R8 dropped with ready", valid, 0);
    repeat (3) @(negedge clk);
    chk(!valid && !busy, "R8 no late capture", {valid, busy}, 0);

    do_reset();
    @(negedge clk);
    chk(!ovr && !valid, "R9 reset clears overrun", ovr, 0);

    // R10: long low pulse gives exactly one capture
    @(negedge clk);
    d = 8'h96; rs = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk(!valid, "R10 nothing while low", valid, 0);
    end
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid && cdata == 8'h96 && crs, "R10 one capture", cdata, 8'h96);
    ack();
    repeat (8) begin
      @(negedge clk);
      chk(!valid && !ovr, "R10 no second capture", {valid, ovr}, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule